// File: doc/BRIEF.md
# Dual-Width Transmit Word Serializer

This block turns parallel transmit words into a serial bit stream, one bit per bit-clock cycle. It runs entirely in the bit-clock domain. A one-cycle strobe, derived from the bit clock, marks each rising edge of the word-rate reference clock. The bit clock runs ten times faster than that reference, so strobes arrive every ten bit cycles.

The width select picks one of two formats. In narrow mode each strobe supplies a 10-bit word taken from the upper half of the 20-bit bus. In wide mode a 20-bit word spans two reference periods, so only every second strobe takes a word.

The serial stream feeds two outputs with identical content: a main line and a loopback line. Each has its own active-low enable. A new word loads on the bit cycle right after the previous word's last bit, so consecutive words stream with no gap.

Top module: `word_serializer`

## Requirements
- R1: With `half_mode` = 1, a strobe captures `par_in[19:10]`, and `par_in[9:0]` has no effect. In the cycle after the capturing clock edge the line shows `par_in[10]`, then bits 11 through 19 on the following nine cycles.
- R2: With `half_mode` = 0, a strobe captures all 20 bits, and the line shows bit 0 first and bit 19 last. Only the first strobe after reset (or after a width-select rising edge) captures, and then every second strobe after it; the strobes in between are ignored.
- R3: When the next capturing strobe falls in the cycle that shows the last bit of the current word, the first bit of the new word follows directly, with no gap bit.
- R4: After reset, and after the last bit of a word when no new word has been captured, both serial outputs are low.
- R5: `main_oe_n` = 1 holds `ser_main` low, and `loop_oe_n` = 1 holds `ser_loop` low, in the same cycle. Each enable leaves the other output unaffected.
- R6: While both enables are low, `ser_main` and `ser_loop` are equal in every cycle.
- R7: A rising edge of `half_mode` clears the block. Both outputs are low from the next cycle. A strobe in the cycle of that edge is ignored, and the next strobe captures.
- R8: While `rst_n` is low, both outputs are low whatever the strobe and bus do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_stb | input | 1 | One-cycle pulse per reference-clock rising edge |
| par_in | input | 20 | Parallel transmit word |
| half_mode | input | 1 | 1 selects 10-bit words, 0 selects 20-bit words |
| main_oe_n | input | 1 | Active-low enable of the main serial output |
| loop_oe_n | input | 1 | Active-low enable of the loopback serial output |
| ser_main | output | 1 | Main serial data |
| ser_loop | output | 1 | Loopback serial data |

## Verification
A bit counter that is off by one shows up within one word. A stream then loses or repeats a bit, or leaves a low gap bit between back-to-back words. A wrong wide-mode phase is just as quick to see: an in-between strobe's data appears on the line, or a real word is dropped, from the next word boundary. Residual shifter contents after a width-select edge or at the end of a word show as high bits on an output that should be idle, within a single cycle.

// File: rtl/word_serializer.sv
module word_serializer #(
  parameter int WORD_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_stb,
  input  logic [WORD_W-1:0] par_in,
  input  logic              half_mode,
  input  logic              main_oe_n,
  input  logic              loop_oe_n,
  output logic              ser_main,
  output logic              ser_loop
);
  localparam int HALF = WORD_W / 2;
  localparam int CW   = $clog2(WORD_W);

  logic [WORD_W-1:0] shreg;
  logic [CW-1:0]     cnt;
  logic              busy, phase, mode_q;

  wire              mode_rise = half_mode & ~mode_q;
  wire              take      = word_stb & ~mode_rise & (half_mode | ~phase);
  wire [CW-1:0]     last      = half_mode ? CW'(HALF - 1) : CW'(WORD_W - 1);
  wire [WORD_W-1:0] load_val  = half_mode ? {{HALF{1'b0}}, par_in[WORD_W-1:HALF]} : par_in;
  wire              bit_q     = busy & shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      cnt    <= '0;
      busy   <= 1'b0;
      phase  <= 1'b0;
      mode_q <= 1'b1;
    end else begin
      mode_q <= half_mode;
      if (mode_rise) begin
        shreg <= '0;
        cnt   <= '0;
        busy  <= 1'b0;
        phase <= 1'b0;
      end else begin
        if (half_mode)     phase <= 1'b0;
        else if (word_stb) phase <= ~phase;
        if (take) begin
          shreg <= load_val;
          cnt   <= '0;
          busy  <= 1'b1;
        end else if (busy) begin
          if (cnt == last) begin
            busy  <= 1'b0;
            shreg <= '0;
          end else begin
            cnt   <= cnt + 1'b1;
            shreg <= shreg >> 1;
          end
        end
      end
    end
  end

  assign ser_main = bit_q & ~main_oe_n;
  assign ser_loop = bit_q & ~loop_oe_n;
endmodule

// File: rtl/word_serializer_chk.sv
module word_serializer_chk #(
  parameter int WORD_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              word_stb,
  input logic [WORD_W-1:0] par_in,
  input logic              half_mode,
  input logic              main_oe_n,
  input logic              loop_oe_n,
  input logic              ser_main,
  input logic              ser_loop
);
  // R5
  main_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    main_oe_n |-> !ser_main);

  // R5
  loop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_oe_n |-> !ser_loop);

  // R6
  mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!main_oe_n && !loop_oe_n) |-> (ser_main == ser_loop));

  // R7
  mode_rise_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(half_mode) |=> (!ser_main && !ser_loop));

  // R1
  narrow_first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_stb && half_mode && !$rose(half_mode) && !main_oe_n)
      |=> (main_oe_n || ser_main == $past(par_in[WORD_W/2])));
endmodule

bind word_serializer word_serializer_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/tb_word_serializer.sv
`timescale 1ns/1ps
module tb_word_serializer;
  logic        clk = 1'b0, rst_n = 1'b0, word_stb = 1'b0, half_mode = 1'b0;
  logic        main_oe_n = 1'b0, loop_oe_n = 1'b0;
  logic [19:0] par_in = '0;
  wire         ser_main, ser_loop;

  always #2.5 clk = ~clk;

  word_serializer dut (
    .clk(clk), .rst_n(rst_n), .word_stb(word_stb), .par_in(par_in),
    .half_mode(half_mode), .main_oe_n(main_oe_n), .loop_oe_n(loop_oe_n),
    .ser_main(ser_main), .ser_loop(ser_loop)
  );

  typedef struct packed {
    logic            half;
    logic [3:0][19:0] w;
  } row_t;

  localparam row_t ROWS [6] = '{
    '{1'b1, {20'hA53C7, 20'h3F0E1, 20'h5AA5B, 20'hC3924}},
    '{1'b0, {20'h9B1D3, 20'hFFFFF, 20'h2C4E8, 20'h00000}},
    '{1'b1, {20'hFFC00, 20'h003FF, 20'h81F00, 20'h7E0A5}},
    '{1'b0, {20'h80001, 20'h55555, 20'h7FFFE, 20'hAAAAA}},
    '{1'b1, {20'h00000, 20'hFFFFF, 20'h12345, 20'hFEDCB}},
    '{1'b0, {20'hF0F0F, 20'h0F0F0, 20'h13579, 20'hECA86}}
  };

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic stream(input row_t r, input string req);
    int bad = 0;
    logic [1:0] fa = '0, fe = '0;
    half_mode = r.half;
    word_stb  = 1'b0;
    repeat (3) @(negedge clk);
    word_stb = 1'b1;
    par_in   = r.w[0];
    for (int k = 0; k < 40; k++) begin
      logic eb, xm, xl;
      @(negedge clk);
      eb = r.half ? r.w[k/10][10 + k%10] : r.w[(k/20)*2][k%20];
      xm = eb & ~main_oe_n;
      xl = eb & ~loop_oe_n;
      if (ser_main !== xm || ser_loop !== xl) begin
        if (bad == 0) begin
          fa = {ser_main, ser_loop};
          fe = {xm, xl};
        end
        bad++;
      end
      word_stb = ((k + 1) % 10 == 0) && (k + 1 < 40);
      par_in   = word_stb ? r.w[(k+1)/10] : ~par_in;
    end
    chk(bad == 0, req, fa, fe);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(ser_main == 1'b0 && ser_loop == 1'b0, "R4 idle after last bit", {ser_main, ser_loop}, 0);
    end
  endtask

  initial begin
    // R8: outputs low under reset despite strobes
    word_stb = 1'b1;
    par_in   = '1;
    repeat (4) @(negedge clk);
    chk(ser_main == 1'b0 && ser_loop == 1'b0, "R8 low during reset", {ser_main, ser_loop}, 0);
    word_stb = 1'b0;
    rst_n    = 1'b1;
    repeat (3) @(negedge clk);
    chk(ser_main == 1'b0 && ser_loop == 1'b0, "R4 idle after reset", {ser_main, ser_loop}, 0);

    foreach (ROWS[i])
      stream(ROWS[i], ROWS[i].half ? "R1 R3 R6 narrow stream" : "R2 R3 R6 wide stream");

    // R5: each enable gates its own line only
    main_oe_n = 1'b1; loop_oe_n = 1'b0;
    stream(ROWS[0], "R5 main disabled");
    main_oe_n = 1'b0; loop_oe_n = 1'b1;
    stream(ROWS[1], "R5 loop disabled");
    main_oe_n = 1'b1; loop_oe_n = 1'b1;
    stream(ROWS[2], "R5 both disabled");
    main_oe_n = 1'b0; loop_oe_n = 1'b0;

    // R7: width-select rising edge mid-word clears state
    half_mode = 1'b0;
    repeat (3) @(negedge clk);
    word_stb = 1'b1; par_in = '1;
    @(negedge clk);
    word_stb = 1'b0;
    repeat (4) @(negedge clk);
    chk(ser_main == 1'b1, "R2 wide word in flight", ser_main, 1);
    half_mode = 1'b1; word_stb = 1'b1; par_in = '1;
    @(negedge clk);
    word_stb = 1'b0;
    chk(ser_main == 1'b0 && ser_loop == 1'b0, "R7 cleared after rise", {ser_main, ser_loop}, 0);
    begin
      int hi = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (ser_main || ser_loop) hi++;
      end
      chk(hi == 0, "R7 strobe at rise ignored", hi, 0);
    end
    word_stb = 1'b1; par_in = 20'h00400;
    @(negedge clk);
    word_stb = 1'b0;
    chk(ser_main == 1'b1, "R7 next strobe captures bit10", ser_main, 1);
    @(negedge clk);
    chk(ser_main == 1'b0, "R7 next strobe bit11", ser_main, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule